// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Framing Recovery

This block turns an asynchronous serial line into parallel characters. It is paced by a clock-enable that pulses sixteen times per bit period. A falling edge on the line starts a check of the start bit: the line has to stay low for half a bit period before the receiver accepts the start. After that, the receiver samples each data bit, the optional parity bit and one stop bit once per bit period, near the middle of the bit. Characters are 5 to 8 bits long and are sent least significant bit first. Each finished character is placed in a holding register with ready, parity-error, framing-error, overrun and break flags.

A framing error on a non-zero character does not make the receiver wait for the line to go idle. If the line is still low half a bit period after the bad stop sample, that low level is taken as the next start bit. A character of all zero bits is reported as a break, and the receiver then waits for the line to return high. The ready-to-send output is active while the receiver is enabled and has no overrun pending. It drops on its own when a character arrives while the previous one is still unread. A read strobe empties the holding register and clears all flags.

Top module: `srx_top`

## Requirements
- R1: After reset, rx_rdy, rx_data and all four flags are zero, and rts_ok equals rx_en.
- R2: A low level on the line that lasts fewer than eight ticks is rejected and produces no character.
- R3: Data bits are taken least significant first, one per 16 ticks, near the middle of each bit.
- R4: char_len selects 5 (00), 6 (01), 7 (10) or 8 (11) data bits, and the unused upper bits of rx_data read as zero.
- R5: When par_en is 1, a parity bit follows the data. With par_odd=0 the expected bit is the XOR of the data bits, and with par_odd=1 it is the inverse of that XOR. err_par is set when the received bit differs from the expected bit.
- R6: After a high stop bit, a start bit that follows directly, with no idle time, is accepted.
- R7: A low stop-bit sample sets err_frm for that character.
- R8: When a non-zero character has a low stop sample and the line is still low eight ticks later, a new character starts without a new falling edge.
- R9: When the data, parity and stop samples are all zero, rx_brk and err_frm are both set. No new character starts until the line has been high.
- R10: A finished character is loaded and sets rx_rdy when the register is empty or is read in the same cycle. A one-cycle rd_stb clears rx_rdy and all four flags.
- R11: If a character finishes while rx_rdy is set and no read happens in that cycle, err_ovr is set. The new character is dropped, and rx_data and the other flags keep their values.
- R12: rts_ok is 1 exactly when rx_en is 1 and err_ovr is 0. It drops in the cycle after an overrun.
- R13: While rx_en is 0, no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable that pulses 16 times per bit period |
| rx_en | input | 1 | Receiver enable |
| rxd | input | 1 | Serial line input (idle high) |
| char_len | input | 2 | Number of data bits: 00=5, 01=6, 10=7, 11=8 |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_stb | input | 1 | Read strobe: empties the holding register |
| rx_data | output | DW | Holding register |
| rx_rdy | output | 1 | Holding register holds an unread character |
| err_par | output | 1 | Parity error for the held character |
| err_frm | output | 1 | Framing error for the held character |
| err_ovr | output | 1 | A character was dropped because the register was full |
| rx_brk | output | 1 | Break received |
| rts_ok | output | 1 | Ready-to-send, active high |

## Verification
The assertions check on every cycle the rules between the holding register and its flags. They cover loading into an empty register, clearing on read, an overrun that keeps the old data and drops rts_ok, the zero upper bits after a load, a break that always comes with a framing error, and no completions while disabled. Other behaviours depend on how the serial waveform unfolds over time. These are start-bit rejection of short glitches, bit order and the centre sampling point, parity polarity, back-to-back characters, the restart after a framing error, and waiting for a high line after a break. Only the bench's scenarios can show them, by driving whole characters and reading the results at the ports.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_FECHK,
    S_WAITHI
  } srx_state_e;

  // number of data bits selected by the two-bit length code
  function automatic int unsigned char_bits(input logic [1:0] len, input int unsigned dw);
    return dw - 3 + int'(len);
  endfunction

  // parity bit the sender should have placed after the data
  function automatic logic par_expect(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          line,
  input  logic [1:0]    char_len,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          done,
  output logic [DW-1:0] done_data,
  output logic          done_pe,
  output logic          done_fe,
  output logic          done_brk
);
  localparam int CW   = $clog2(OVS);
  localparam int IW   = $clog2(DW);
  localparam int HALF = OVS / 2;

  srx_state_e    state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [IW-1:0] bidx, bidx_n;
  logic [DW-1:0] sh, sh_n;
  logic          pbit, pbit_n;
  logic          line_q, line_q_n;
  logic [IW-1:0] last_idx;
  logic          bit_end;
  logic          zero_char;

  assign last_idx  = IW'(char_bits(char_len, DW) - 1);
  assign bit_end   = (cnt == CW'(OVS - 1));
  assign zero_char = (sh == '0) && !(par_en && pbit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      line_q <= 1'b1;
    end else begin
      state  <= state_n;
      cnt    <= cnt_n;
      bidx   <= bidx_n;
      sh     <= sh_n;
      pbit   <= pbit_n;
      line_q <= line_q_n;
    end
  end

  always_comb begin
    state_n  = state;
    cnt_n    = cnt;
    bidx_n   = bidx;
    sh_n     = sh;
    pbit_n   = pbit;
    line_q_n = line_q;
    done     = 1'b0;
    done_pe  = 1'b0;
    done_fe  = 1'b0;
    done_brk = 1'b0;
    if (!en) begin
      state_n = S_IDLE;
      cnt_n   = '0;
      if (tick) line_q_n = line;
    end else if (tick) begin
      line_q_n = line;
      unique case (state)
        S_IDLE: begin
          if (line_q && !line) begin
            state_n = S_START;
            cnt_n   = '0;
          end
        end
        S_START: begin
          if (line) begin
            state_n = S_IDLE;
          end else if (cnt == CW'(HALF - 1)) begin
            state_n = S_DATA;
            cnt_n   = '0;
            bidx_n  = '0;
            sh_n    = '0;
            pbit_n  = 1'b0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        S_DATA: begin
          if (bit_end) begin
            cnt_n      = '0;
            sh_n[bidx] = line;
            if (bidx == last_idx) state_n = par_en ? S_PAR : S_STOP;
            else                  bidx_n  = bidx + 1'b1;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        S_PAR: begin
          if (bit_end) begin
            cnt_n   = '0;
            pbit_n  = line;
            state_n = S_STOP;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        S_STOP: begin
          if (bit_end) begin
            cnt_n    = '0;
            done     = 1'b1;
            done_pe  = par_en && (pbit != par_expect(8'(sh), par_odd));
            done_fe  = !line;
            done_brk = !line && zero_char;
            if (line)           state_n = S_IDLE;
            else if (sh != '0)  state_n = S_FECHK;
            else                state_n = S_WAITHI;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        S_FECHK: begin
          if (line) begin
            state_n = S_IDLE;
          end else if (cnt == CW'(HALF - 1)) begin
            state_n = S_START;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt + 1'b1;
          end
        end
        S_WAITHI: begin
          if (line) state_n = S_IDLE;
        end
        default: state_n = S_IDLE;
      endcase
    end
  end

  assign done_data = sh;
endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          done,
  input  logic [DW-1:0] d_data,
  input  logic          d_pe,
  input  logic          d_fe,
  input  logic          d_brk,
  input  logic          rd,
  output logic          load_ev,
  output logic          ovr_ev,
  output logic [DW-1:0] data,
  output logic          rdy,
  output logic          pe,
  output logic          fe,
  output logic          ovr,
  output logic          brk,
  output logic          rts
);
  logic full;

  assign full    = rdy && !rd;
  assign load_ev = done && !full;
  assign ovr_ev  = done && full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      rdy  <= 1'b0;
      pe   <= 1'b0;
      fe   <= 1'b0;
      ovr  <= 1'b0;
      brk  <= 1'b0;
    end else begin
      if (rd) begin
        rdy <= 1'b0;
        pe  <= 1'b0;
        fe  <= 1'b0;
        ovr <= 1'b0;
        brk <= 1'b0;
      end
      if (load_ev) begin
        data <= d_data;
        rdy  <= 1'b1;
        pe   <= d_pe;
        fe   <= d_fe;
        brk  <= d_brk;
      end
      if (ovr_ev) ovr <= 1'b1;
    end
  end

  assign rts = en && !ovr;
endmodule

// File: rtl/srx_top.sv
module srx_top #(
  parameter int OVS       = 16,
  parameter int DW        = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rx_en,
  input  logic          rxd,
  input  logic [1:0]    char_len,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          rd_stb,
  output logic [DW-1:0] rx_data,
  output logic          rx_rdy,
  output logic          err_par,
  output logic          err_frm,
  output logic          err_ovr,
  output logic          rx_brk,
  output logic          rts_ok
);
  logic          line_s;
  logic          frame_done;
  logic [DW-1:0] done_data;
  logic          done_pe, done_fe, done_brk;
  logic          load_ev, ovr_ev;

  srx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (line_s)
  );

  srx_frame #(.OVS(OVS), .DW(DW)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .en        (rx_en),
    .line      (line_s),
    .char_len  (char_len),
    .par_en    (par_en),
    .par_odd   (par_odd),
    .done      (frame_done),
    .done_data (done_data),
    .done_pe   (done_pe),
    .done_fe   (done_fe),
    .done_brk  (done_brk)
  );

  srx_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (rx_en),
    .done    (frame_done),
    .d_data  (done_data),
    .d_pe    (done_pe),
    .d_fe    (done_fe),
    .d_brk   (done_brk),
    .rd      (rd_stb),
    .load_ev (load_ev),
    .ovr_ev  (ovr_ev),
    .data    (rx_data),
    .rdy     (rx_rdy),
    .pe      (err_par),
    .fe      (err_frm),
    .ovr     (err_ovr),
    .brk     (rx_brk),
    .rts     (rts_ok)
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk
  import srx_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic [1:0]    char_len,
  input logic          rd_stb,
  input logic          frame_done,
  input logic          load_ev,
  input logic          ovr_ev,
  input logic [DW-1:0] done_data,
  input logic [DW-1:0] rx_data,
  input logic          rx_rdy,
  input logic          err_par,
  input logic          err_frm,
  input logic          err_ovr,
  input logic          rx_brk,
  input logic          rts_ok
);
  a_r10_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> rx_rdy && (rx_data == $past(done_data)));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !frame_done) |=> !rx_rdy && !err_par && !err_frm && !err_ovr && !rx_brk);

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> ((rx_data >> char_bits($past(char_len), DW)) == '0));

  a_r11_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev |=> err_ovr && rx_rdy && (rx_data == $past(rx_data)));

  a_r11_ovr_needs_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovr |-> rx_rdy);

  a_r12_rts_low_on_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ovr || !rx_en) |-> !rts_ok);

  a_r9_break_has_fe: assert property (@(posedge clk) disable iff (!rst_n)
    rx_brk |-> err_frm);

  a_r13_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !frame_done);
endmodule

bind srx_top srx_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .char_len   (char_len),
  .rd_stb     (rd_stb),
  .frame_done (frame_done),
  .load_ev    (load_ev),
  .ovr_ev     (ovr_ev),
  .done_data  (done_data),
  .rx_data    (rx_data),
  .rx_rdy     (rx_rdy),
  .err_par    (err_par),
  .err_frm    (err_frm),
  .err_ovr    (err_ovr),
  .rx_brk     (rx_brk),
  .rts_ok     (rts_ok)
);

// File: tb/test_srx_top.sv
`timescale 1ns/1ps
module test_srx_top;
  localparam int BITCLK = 64;   // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16;
  logic       rx_en = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] char_len = 2'b11;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       rd_stb = 1'b0;
  logic [7:0] rx_data;
  logic       rx_rdy, err_par, err_frm, err_ovr, rx_brk, rts_ok;
  logic [1:0] tcnt = 2'd0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 2'd1;
  assign tick16 = (tcnt == 2'd3);

  srx_top i_srx_top (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_en(rx_en), .rxd(rxd),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .rd_stb(rd_stb),
    .rx_data(rx_data), .rx_rdy(rx_rdy), .err_par(err_par), .err_frm(err_frm),
    .err_ovr(err_ovr), .rx_brk(rx_brk), .rts_ok(rts_ok)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic slot(input logic v);
    rxd = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] v, input int nb, input logic pb, input logic stopv);
    slot(1'b0);
    for (int i = 0; i < nb; i++) slot(v[i]);
    if (par_en) slot(pb);
    slot(stopv);
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_rdy(output bit got);
    got = 0;
    for (int i = 0; i < BITCLK * 14; i++) begin
      if (rx_rdy) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic expect_char(input string req, input logic [7:0] d,
                             input logic pe, input logic fe, input logic brk);
    chk(req, "rdy", rx_rdy, 1);
    chk(req, "data", rx_data, d);
    chk(req, "err_par", err_par, pe);
    chk(req, "err_frm", err_frm, fe);
    chk(req, "rx_brk", rx_brk, brk);
  endtask

  task automatic t_reset();
    chk("R1", "rdy", rx_rdy, 0);
    chk("R1", "data", rx_data, 0);
    chk("R1", "flags", {err_par, err_frm, err_ovr, rx_brk}, 0);
    chk("R1", "rts_ok", rts_ok, 1);
  endtask

  task automatic t_basic();
    send(8'hA6, 8, 1'b0, 1'b1);
    expect_char("R3", 8'hA6, 0, 0, 0);
    do_read();
    chk("R10", "rdy after read", rx_rdy, 0);
    send(8'h01, 8, 1'b0, 1'b1);
    expect_char("R3", 8'h01, 0, 0, 0);
    do_read();
  endtask

  task automatic t_glitch();
    rxd = 1'b0; repeat (12) @(negedge clk);
    rxd = 1'b1; repeat (BITCLK * 12) @(negedge clk);
    chk("R2", "rdy after 3-tick glitch", rx_rdy, 0);
    rxd = 1'b0; repeat (24) @(negedge clk);
    rxd = 1'b1; repeat (BITCLK * 12) @(negedge clk);
    chk("R2", "rdy after 6-tick glitch", rx_rdy, 0);
    send(8'h5A, 8, 1'b0, 1'b1);
    expect_char("R2", 8'h5A, 0, 0, 0);
    do_read();
  endtask

  task automatic t_lengths();
    send(8'hFF, 8, 1'b0, 1'b1);
    do_read();
    char_len = 2'b00;
    send(8'h15, 5, 1'b0, 1'b1);
    expect_char("R4", 8'h15, 0, 0, 0);
    do_read();
    char_len = 2'b01;
    send(8'h2A, 6, 1'b0, 1'b1);
    expect_char("R4", 8'h2A, 0, 0, 0);
    do_read();
    char_len = 2'b10;
    send(8'h7E, 7, 1'b0, 1'b1);
    expect_char("R4", 8'h7E, 0, 0, 0);
    do_read();
    char_len = 2'b11;
  endtask

  task automatic t_parity();
    par_en = 1'b1; par_odd = 1'b0;
    send(8'h35, 8, 1'b0, 1'b1);
    expect_char("R5", 8'h35, 0, 0, 0);
    do_read();
    send(8'h35, 8, 1'b1, 1'b1);
    expect_char("R5", 8'h35, 1, 0, 0);
    do_read();
    par_odd = 1'b1;
    send(8'h35, 8, 1'b1, 1'b1);
    expect_char("R5", 8'h35, 0, 0, 0);
    do_read();
    char_len = 2'b10;
    send(8'h41, 7, 1'b0, 1'b1);
    expect_char("R5", 8'h41, 1, 0, 0);
    do_read();
    char_len = 2'b11; par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_back2back();
    bit got;
    fork
      begin
        send(8'h3C, 8, 1'b0, 1'b1);
        send(8'hC3, 8, 1'b0, 1'b1);
      end
      begin
        wait_rdy(got);
        expect_char("R6", 8'h3C, 0, 0, 0);
        do_read();
        wait_rdy(got);
        chk("R6", "second char arrived", got, 1);
        expect_char("R6", 8'hC3, 0, 0, 0);
        do_read();
      end
    join
  endtask

  task automatic t_fe_restart();
    bit got;
    fork
      begin
        send(8'h55, 8, 1'b0, 1'b0);
        send(8'hA3, 8, 1'b0, 1'b1);
      end
      begin
        wait_rdy(got);
        expect_char("R7", 8'h55, 0, 1, 0);
        do_read();
        wait_rdy(got);
        chk("R8", "restarted char arrived", got, 1);
        expect_char("R8", 8'hA3, 0, 0, 0);
        do_read();
      end
    join
  endtask

  task automatic t_break();
    send(8'h00, 8, 1'b0, 1'b0);
    expect_char("R9", 8'h00, 0, 1, 1);
    do_read();
    repeat (BITCLK * 3) @(negedge clk);
    chk("R9", "no char while line held low", rx_rdy, 0);
    slot(1'b1);
    send(8'h81, 8, 1'b0, 1'b1);
    expect_char("R9", 8'h81, 0, 0, 0);
    do_read();
  endtask

  task automatic t_overrun();
    send(8'h12, 8, 1'b0, 1'b1);
    chk("R12", "rts before overrun", rts_ok, 1);
    send(8'h34, 8, 1'b0, 1'b0);
    chk("R11", "err_ovr", err_ovr, 1);
    expect_char("R11", 8'h12, 0, 0, 0);
    chk("R12", "rts after overrun", rts_ok, 0);
    do_read();
    chk("R10", "flags cleared", {rx_rdy, err_par, err_frm, err_ovr, rx_brk}, 0);
    chk("R12", "rts after read", rts_ok, 1);
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    @(negedge clk);
    chk("R12", "rts while disabled", rts_ok, 0);
    send(8'h66, 8, 1'b0, 1'b1);
    chk("R13", "rdy while disabled", rx_rdy, 0);
    rx_en = 1'b1;
    slot(1'b1);
    chk("R12", "rts re-enabled", rts_ok, 1);
    send(8'h99, 8, 1'b0, 1'b1);
    expect_char("R13", 8'h99, 0, 0, 0);
    do_read();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    slot(1'b1);
    t_basic();
    t_glitch();
    t_lengths();
    t_parity();
    t_back2back();
    t_fe_restart();
    t_break();
    slot(1'b1);
    t_overrun();
    slot(1'b1);
    t_disabled();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule